// File: doc/BRIEF.md
# Receive Elastic Buffer with Idle Rate Matching

This block sits between the byte decoder of a gigabit serial Ethernet receiver and the rest of the receive path. Decoded bytes, each with a flag marking it as a control character, arrive on the recovered receive clock. They leave on the local clock. The two clocks are nominally equal but drift apart, so the block holds a 32-entry store and keeps its fill level near the middle. It does this by discarding or repeating complete two-byte idle ordered sets, and it never touches frame contents.

An idle set is recognised as a control byte 0xBC (K28.5) followed by a data byte 0x50 (D16.2). The write side runs a three-state machine. In `WR_EMPTY` no byte is staged. In `WR_HOLD` an ordinary byte is staged. In `WR_HOLD_K` a K28.5 is staged while the block waits to see whether the next byte completes an idle set. Every byte enters the stage. Moving on to another byte commits the staged one to storage, except on the drop path, which takes `WR_HOLD_K` to `WR_EMPTY`. Each arriving byte moves the machine to `WR_HOLD_K` if it is a K28.5, and to `WR_HOLD` otherwise.

The read side runs a five-state machine:
- `RD_PRIME` waits until the store is half full, then moves to `RD_STREAM`.
- `RD_STREAM` and `RD_GOT_K` pop one entry per clock. `RD_GOT_K` means the last byte popped was a K28.5.
- If `RD_GOT_K` pops a D16.2 while the store is low, the machine enters `RD_INS_K`.
- `RD_INS_K` re-emits the K byte and always moves to `RD_INS_D`.
- `RD_INS_D` re-emits the D byte. It loops back to `RD_INS_K` while the store is still low, and otherwise returns to `RD_STREAM`.
- Popping from an empty store returns the machine to `RD_PRIME`.

Read and write pointers cross the clock boundary in Gray code through two synchronizing flops. Each side computes its own occupancy from them.

Top module: `rx_elastic_buf`

## Requirements
- R1: While either reset is low, and directly after reset, `rd_valid`, `wr_overflow` and `rd_underflow` are 0 and `rd_level` is 0.
- R2: After reset, and after each underflow, `rd_valid` stays 0 until the read-side level reaches 16. Then the read side produces one byte on every `rd_clk` cycle.
- R3: An idle set is exactly a byte 0xBC with control flag 1 followed directly by a byte 0x50 with control flag 0. No other pair is treated as one. This includes 0xBC,0x50 sent as data, and 0xBC followed by any other byte.
- R4: When a complete idle set arrives and the write-side level is at least 23, both of its bytes are discarded. This threshold is half plus one, plus twice the three-cycle pointer transfer lag. With a write clock faster than the read clock, fewer idle sets leave than enter and no overflow occurs.
- R5: After an idle set has been read out, if the read-side level is at most 15, the same set is emitted again. This repeats with no limit while the level stays at most 15. With a slower write clock, more idle sets leave than enter and no underflow occurs.
- R6: Every byte that is not part of an idle set leaves in arrival order, exactly once. This covers frame bytes, start, end and carrier-extend codes, and other ordered sets.
- R7: A commit while the write-side level is 32 discards that byte, sets `wr_overflow`, and moves the write pointer to 16 ahead of the synchronized read pointer. `wr_overflow` stays 1 until reset.
- R8: A pop with a read-side level of 0 sets `rd_underflow`, drops `rd_valid` and returns to priming. `rd_underflow` stays 1 until reset.
- R9: `rd_level` is the read-side occupancy and never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write side |
| wr_data | input | 8 | Decoded byte |
| wr_ctrl | input | 1 | 1 when `wr_data` is a control character |
| wr_valid | input | 1 | Byte present this cycle |
| wr_overflow | output | 1 | Sticky overflow flag, write clock domain |
| rd_clk | input | 1 | Local system clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read side |
| rd_data | output | 8 | Output byte |
| rd_ctrl | output | 1 | Control flag of `rd_data` |
| rd_valid | output | 1 | Output byte is meaningful |
| rd_underflow | output | 1 | Sticky underflow flag, read clock domain |
| rd_level | output | 6 | Read-side occupancy, 0 to 32 |

## Verification
On the read side, replaying an idle set competes in the same cycles with new frame bytes landing in the store. The bench provokes this by running the write clock about 15 percent slow, so replays run while frames keep arriving. A scoreboard then confirms that every non-idle byte emerges once and in order, and that the count of idle sets rises. On the write side, the drop decision for an idle set coincides with the commit of the byte staged before it. A write clock about 10 percent fast provokes this, and the bench judges it by a falling idle count with the frame stream intact and no overflow.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    localparam logic [7:0] SYM_K28_5 = 8'hBC;
    localparam logic [7:0] SYM_D16_2 = 8'h50;

    typedef struct packed {
        logic       ctrl;
        logic [7:0] data;
    } ebuf_sym_t;

    typedef enum logic [1:0] {
        WR_EMPTY,
        WR_HOLD,
        WR_HOLD_K
    } wr_state_t;

    typedef enum logic [2:0] {
        RD_PRIME,
        RD_STREAM,
        RD_GOT_K,
        RD_INS_K,
        RD_INS_D
    } rd_state_t;

    function automatic logic is_idle_k(input ebuf_sym_t s);
        return s.ctrl && (s.data == SYM_K28_5);
    endfunction

    function automatic logic is_idle_d(input ebuf_sym_t s);
        return !s.ctrl && (s.data == SYM_D16_2);
    endfunction

endpackage

// File: rtl/ebuf_gray_sync.sv
module ebuf_gray_sync #(
    parameter int PW     = 6,
    parameter int STAGES = 2
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [PW-1:0] src_bin,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [PW-1:0] dst_bin
);

    logic [PW-1:0] gray_src;
    logic [PW-1:0] sync_q [STAGES];

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            gray_src <= '0;
        end else begin
            gray_src <= src_bin ^ (src_bin >> 1);
        end
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                sync_q[i] <= '0;
            end
        end else begin
            sync_q[0] <= gray_src;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign dst_bin = gray_to_bin(sync_q[STAGES-1]);

endmodule

// File: rtl/ebuf_store.sv
module ebuf_store #(
    parameter int DEPTH = 32,
    parameter int W     = 9
) (
    input  logic                     wclk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ebuf_wr_ctl.sv
module ebuf_wr_ctl
    import ebuf_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int REMOVE_LVL = 23
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  ebuf_sym_t                        in_sym,
    input  logic                             in_valid,
    input  logic [$clog2(DEPTH):0]           rptr_sync,
    output logic [$clog2(DEPTH):0]           wptr,
    output logic [$clog2(DEPTH):0]           occ,
    output logic                             we,
    output ebuf_sym_t                        wsym,
    output logic                             overflow
);

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] FULL_P   = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P   = PW'(DEPTH / 2);
    localparam logic [PW-1:0] REMOVE_P = PW'(REMOVE_LVL);
    localparam logic [PW-1:0] ONE_P    = PW'(1);

    wr_state_t state, state_nx;
    ebuf_sym_t stage, stage_nx;
    logic      commit;
    logic      full;

    assign occ  = wptr - rptr_sync;
    assign full = (occ >= FULL_P);
    assign wsym = stage;
    assign we   = commit && !full;

    always_comb begin
        state_nx = state;
        stage_nx = stage;
        commit   = 1'b0;
        if (in_valid) begin
            unique case (state)
                WR_EMPTY: begin
                    stage_nx = in_sym;
                    state_nx = is_idle_k(in_sym) ? WR_HOLD_K : WR_HOLD;
                end
                WR_HOLD: begin
                    commit   = 1'b1;
                    stage_nx = in_sym;
                    state_nx = is_idle_k(in_sym) ? WR_HOLD_K : WR_HOLD;
                end
                WR_HOLD_K: begin
                    if (is_idle_d(in_sym) && (occ >= REMOVE_P)) begin
                        state_nx = WR_EMPTY;
                    end else begin
                        commit   = 1'b1;
                        stage_nx = in_sym;
                        state_nx = is_idle_k(in_sym) ? WR_HOLD_K : WR_HOLD;
                    end
                end
                default: state_nx = WR_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage    <= '0;
            wptr     <= '0;
            overflow <= 1'b0;
        end else begin
            stage <= stage_nx;
            if (commit && full) begin
                overflow <= 1'b1;
                wptr     <= rptr_sync + HALF_P;
            end else if (we) begin
                wptr <= wptr + ONE_P;
            end
        end
    end

endmodule

// File: rtl/ebuf_rd_ctl.sv
module ebuf_rd_ctl
    import ebuf_pkg::*;
#(
    parameter int DEPTH      = 32,
    parameter int INSERT_LVL = 15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [$clog2(DEPTH):0] wptr_sync,
    input  ebuf_sym_t              head,
    output logic [$clog2(DEPTH):0] rptr,
    output logic [$clog2(DEPTH):0] occ,
    output logic                   pop,
    output ebuf_sym_t              out_sym,
    output logic                   out_valid,
    output logic                   underflow
);

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] HALF_P   = PW'(DEPTH / 2);
    localparam logic [PW-1:0] INSERT_P = PW'(INSERT_LVL);
    localparam logic [PW-1:0] ONE_P    = PW'(1);
    localparam ebuf_sym_t     IDLE_K   = '{ctrl: 1'b1, data: SYM_K28_5};
    localparam ebuf_sym_t     IDLE_D   = '{ctrl: 1'b0, data: SYM_D16_2};

    rd_state_t state, state_nx;
    ebuf_sym_t sym_nx;
    logic      valid_nx;
    logic      unf_set;

    assign occ = wptr_sync - rptr;

    always_comb begin
        state_nx = state;
        sym_nx   = out_sym;
        valid_nx = out_valid;
        pop      = 1'b0;
        unf_set  = 1'b0;
        unique case (state)
            RD_PRIME: begin
                valid_nx = 1'b0;
                if (occ >= HALF_P) begin
                    state_nx = RD_STREAM;
                end
            end
            RD_STREAM, RD_GOT_K: begin
                if (occ == '0) begin
                    unf_set  = 1'b1;
                    valid_nx = 1'b0;
                    state_nx = RD_PRIME;
                end else begin
                    pop      = 1'b1;
                    valid_nx = 1'b1;
                    sym_nx   = head;
                    if (is_idle_k(head)) begin
                        state_nx = RD_GOT_K;
                    end else if ((state == RD_GOT_K) && is_idle_d(head)
                                 && (occ <= INSERT_P)) begin
                        state_nx = RD_INS_K;
                    end else begin
                        state_nx = RD_STREAM;
                    end
                end
            end
            RD_INS_K: begin
                valid_nx = 1'b1;
                sym_nx   = IDLE_K;
                state_nx = RD_INS_D;
            end
            RD_INS_D: begin
                valid_nx = 1'b1;
                sym_nx   = IDLE_D;
                state_nx = (occ <= INSERT_P) ? RD_INS_K : RD_STREAM;
            end
            default: state_nx = RD_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_PRIME;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sym   <= '0;
            out_valid <= 1'b0;
            underflow <= 1'b0;
            rptr      <= '0;
        end else begin
            out_sym   <= sym_nx;
            out_valid <= valid_nx;
            if (unf_set) begin
                underflow <= 1'b1;
            end
            if (pop) begin
                rptr <= rptr + ONE_P;
            end
        end
    end

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf
    import ebuf_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   wr_clk,
    input  logic                   wr_rst_n,
    input  logic [7:0]             wr_data,
    input  logic                   wr_ctrl,
    input  logic                   wr_valid,
    output logic                   wr_overflow,
    input  logic                   rd_clk,
    input  logic                   rd_rst_n,
    output logic [7:0]             rd_data,
    output logic                   rd_ctrl,
    output logic                   rd_valid,
    output logic                   rd_underflow,
    output logic [$clog2(DEPTH):0] rd_level
);

    localparam int AW         = $clog2(DEPTH);
    localparam int PW         = AW + 1;
    localparam int HALF       = DEPTH / 2;
    localparam int SYNC_LAG   = SYNC_STAGES + 1;
    localparam int REMOVE_LVL = HALF + 1 + 2 * SYNC_LAG;
    localparam int INSERT_LVL = HALF - 1;

    logic [PW-1:0] wptr, rptr, wptr_sync, rptr_sync;
    logic [PW-1:0] wr_occ, rd_occ;
    logic          mem_we, rd_pop;
    ebuf_sym_t     wsym, head, out_sym, in_sym;
    logic [8:0]    head_raw;

    assign in_sym = '{ctrl: wr_ctrl, data: wr_data};

    ebuf_wr_ctl #(.DEPTH(DEPTH), .REMOVE_LVL(REMOVE_LVL)) u_wr (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .in_sym   (in_sym),
        .in_valid (wr_valid),
        .rptr_sync(rptr_sync),
        .wptr     (wptr),
        .occ      (wr_occ),
        .we       (mem_we),
        .wsym     (wsym),
        .overflow (wr_overflow)
    );

    ebuf_store #(.DEPTH(DEPTH), .W(9)) u_store (
        .wclk (wr_clk),
        .we   (mem_we),
        .waddr(wptr[AW-1:0]),
        .wdata(wsym),
        .raddr(rptr[AW-1:0]),
        .rdata(head_raw)
    );

    assign head = head_raw;

    ebuf_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_wsync (
        .src_clk  (wr_clk),
        .src_rst_n(wr_rst_n),
        .src_bin  (wptr),
        .dst_clk  (rd_clk),
        .dst_rst_n(rd_rst_n),
        .dst_bin  (wptr_sync)
    );

    ebuf_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_rsync (
        .src_clk  (rd_clk),
        .src_rst_n(rd_rst_n),
        .src_bin  (rptr),
        .dst_clk  (wr_clk),
        .dst_rst_n(wr_rst_n),
        .dst_bin  (rptr_sync)
    );

    ebuf_rd_ctl #(.DEPTH(DEPTH), .INSERT_LVL(INSERT_LVL)) u_rd (
        .clk      (rd_clk),
        .rst_n    (rd_rst_n),
        .wptr_sync(wptr_sync),
        .head     (head),
        .rptr     (rptr),
        .occ      (rd_occ),
        .pop      (rd_pop),
        .out_sym  (out_sym),
        .out_valid(rd_valid),
        .underflow(rd_underflow)
    );

    assign rd_data  = out_sym.data;
    assign rd_ctrl  = out_sym.ctrl;
    assign rd_level = rd_occ;

endmodule

// File: rtl/rx_elastic_buf_chk.sv
module rx_elastic_buf_chk #(
    parameter int DEPTH = 32
) (
    input logic                   wr_clk,
    input logic                   wr_rst_n,
    input logic                   rd_clk,
    input logic                   rd_rst_n,
    input logic                   wr_overflow,
    input logic                   rd_underflow,
    input logic                   rd_valid,
    input logic [$clog2(DEPTH):0] rd_level,
    input logic                   mem_we,
    input logic [$clog2(DEPTH):0] wr_occ,
    input logic                   rd_pop,
    input logic [$clog2(DEPTH):0] rd_occ
);

    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] FULL_L = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_L = PW'(DEPTH / 2);

    // R7
    ovf_sticky_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_overflow |=> wr_overflow);

    // R7
    no_write_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        mem_we |-> (wr_occ < FULL_L));

    // R8
    unf_sticky_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_underflow |=> rd_underflow);

    // R8
    no_pop_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_pop |-> (rd_occ != '0));

    // R9
    level_bound_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_level <= FULL_L);

    // R2
    prime_gate_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $rose(rd_valid) |-> ($past(rd_level, 2) >= HALF_L));

endmodule

bind rx_elastic_buf rx_elastic_buf_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .wr_overflow (wr_overflow),
    .rd_underflow(rd_underflow),
    .rd_valid    (rd_valid),
    .rd_level    (rd_level),
    .mem_we      (mem_we),
    .wr_occ      (wr_occ),
    .rd_pop      (rd_pop),
    .rd_occ      (rd_occ)
);

// File: tb/tb_rx_elastic_buf.sv
`timescale 1ns/1ps
module tb_rx_elastic_buf;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_ctrl = 1'b0, wr_valid = 1'b0;
    logic       wr_overflow, rd_ctrl, rd_valid, rd_underflow;
    logic [7:0] rd_data;
    logic [5:0] rd_level;

    realtime whalf = 2.0;
    int vectors = 0, fails = 0;
    int i2_in = 0, i2_out = 0;
    int max_level = 0;
    bit sb_on = 1'b1;
    bit pend_k = 1'b0;
    logic [8:0] sbq[$];

    rx_elastic_buf dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
        .wr_ctrl(wr_ctrl), .wr_valid(wr_valid), .wr_overflow(wr_overflow),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_data(rd_data),
        .rd_ctrl(rd_ctrl), .rd_valid(rd_valid), .rd_underflow(rd_underflow),
        .rd_level(rd_level)
    );

    always #2 rd_clk = ~rd_clk;
    initial begin
        #1;
        forever #(whalf) wr_clk = ~wr_clk;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic k, input bit push);
        @(negedge wr_clk);
        wr_data  = d;
        wr_ctrl  = k;
        wr_valid = 1'b1;
        if (push) sbq.push_back({k, d});
    endtask

    task automatic send_i2();
        send(8'hBC, 1'b1, 1'b0);
        send(8'h50, 1'b0, 1'b0);
        i2_in++;
    endtask

    // frame: start code, data BC,50 (not an idle set, R3), payload, end, extend, then /I1/ and idle sets
    task automatic send_frame(input int len, input int seed, input int gap);
        send(8'hFB, 1'b1, 1'b1);
        send(8'hBC, 1'b0, 1'b1);
        send(8'h50, 1'b0, 1'b1);
        for (int i = 0; i < len; i++) send(8'(seed + i * 37), 1'b0, 1'b1);
        send(8'hFD, 1'b1, 1'b1);
        send(8'hF7, 1'b1, 1'b1);
        if (gap > 0) begin
            send(8'hBC, 1'b1, 1'b1);
            send(8'hC5, 1'b0, 1'b1);
            repeat (gap) send_i2();
        end
    endtask

    task automatic drain();
        int n = 0;
        while (sbq.size() != 0 && n < 3000) begin
            send_i2();
            n++;
        end
        repeat (4) send_i2();
        chk(sbq.size() == 0, "R6 drain", 32'(sbq.size()), 0);
    endtask

    task automatic compare(input logic [8:0] got);
        logic [8:0] exp;
        if (sbq.size() == 0) begin
            chk(1'b0, "R6 unexpected byte", 32'(got), 0);
        end else begin
            exp = sbq.pop_front();
            chk(got == exp, "R6 order (R3 pairs)", 32'(got), 32'(exp));
        end
    endtask

    // monitor: scoreboard compare, idle sets counted apart
    always @(negedge rd_clk) begin
        if (!rd_rst_n) begin
            pend_k = 1'b0;
        end else begin
            if (int'(rd_level) > max_level) max_level = int'(rd_level);
            if (rd_valid && sb_on) begin
                if (pend_k) begin
                    pend_k = 1'b0;
                    if (!rd_ctrl && rd_data == 8'h50) begin
                        i2_out++;
                    end else begin
                        compare({1'b1, 8'hBC});
                        if (rd_ctrl && rd_data == 8'hBC) pend_k = 1'b1;
                        else compare({rd_ctrl, rd_data});
                    end
                end else if (rd_ctrl && rd_data == 8'hBC) begin
                    pend_k = 1'b1;
                end else begin
                    compare({rd_ctrl, rd_data});
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge rd_clk);
        wr_valid = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (6) @(negedge rd_clk);
        chk(rd_valid == 1'b0, "R1 rd_valid", 32'(rd_valid), 0);
        chk(wr_overflow == 1'b0, "R1 overflow", 32'(wr_overflow), 0);
        chk(rd_underflow == 1'b0, "R1 underflow", 32'(rd_underflow), 0);
        chk(rd_level == 6'd0, "R1 level", 32'(rd_level), 0);
        sbq.delete();
        sb_on = 1'b1;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (2) @(negedge rd_clk);
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        fails++;
        vectors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int base_in, base_out;
        do_reset();

        // R2: priming hold-off
        repeat (6) send_i2();
        chk(rd_valid == 1'b0, "R2 held before half", 32'(rd_valid), 0);
        for (int f = 0; f < 6; f++) send_frame(18 + f, f * 11, 3);
        drain();
        chk(rd_valid == 1'b1, "R2 streaming", 32'(rd_valid), 1);
        chk(!wr_overflow && !rd_underflow, "R6 equal clocks clean", 32'({wr_overflow, rd_underflow}), 0);

        // R4: fast writer, idle removal
        whalf = 1.8;
        base_in = i2_in; base_out = i2_out;
        for (int f = 0; f < 30; f++) send_frame(20, f * 7 + 3, 4);
        drain();
        chk((i2_out - base_out) < (i2_in - base_in), "R4 idles removed", 32'(i2_out - base_out), 32'(i2_in - base_in));
        chk(wr_overflow == 1'b0, "R4 no overflow", 32'(wr_overflow), 0);

        // R5: slow writer, idle insertion
        whalf = 2.3;
        base_in = i2_in; base_out = i2_out;
        for (int f = 0; f < 30; f++) send_frame(20, f * 5 + 1, 4);
        drain();
        chk((i2_out - base_out) > (i2_in - base_in), "R5 idles inserted", 32'(i2_out - base_out), 32'(i2_in - base_in));
        chk(rd_underflow == 1'b0, "R5 no underflow", 32'(rd_underflow), 0);

        // R8: writer stops mid-stream
        whalf = 2.0;
        send_frame(40, 99, 0);
        @(negedge wr_clk) wr_valid = 1'b0;
        repeat (120) @(negedge rd_clk);
        chk(rd_underflow == 1'b1, "R8 underflow set", 32'(rd_underflow), 1);
        chk(rd_valid == 1'b0, "R8 output stopped", 32'(rd_valid), 0);
        repeat (10) send_i2();
        send_frame(16, 42, 3);
        drain();
        chk(rd_underflow == 1'b1, "R8 underflow sticky", 32'(rd_underflow), 1);

        // R7: writer far too fast
        sb_on = 1'b0;
        whalf = 0.5;
        for (int i = 0; i < 200; i++) send(8'(i), 1'b0, 1'b0);
        chk(wr_overflow == 1'b1, "R7 overflow set", 32'(wr_overflow), 1);
        whalf = 2.0;
        repeat (30) send_i2();
        chk(wr_overflow == 1'b1, "R7 overflow sticky", 32'(wr_overflow), 1);
        chk(max_level <= 32, "R9 level bound", 32'(max_level), 32);

        do_reset();
        repeat (8) send_i2();
        send_frame(12, 5, 3);
        drain();
        chk(!wr_overflow && !rd_underflow, "R1 clean after reset", 32'({wr_overflow, rd_underflow}), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule